// File: doc/BRIEF.md
# Interrupt Line Aggregator with Posted Message Output

This block gathers up to eleven interrupt lines from a bus bridge and turns them into a single posted write, an address and a data word, aimed at a processor's external-interrupt target. An edge on a line is recorded when the line's level changes in either direction. A line that software has enabled also raises a request. The first time a request bit sets, the block launches one message. It holds that message on its output until the fabric acknowledges it.

Software reaches five registers through a simple strobe interface: an enable mask, a pending register and a request register that both clear on read, a read-only live-level view of the raw inputs, and a target word that packs the message address and data into one value. Edges on lines that are not enabled never turn into messages. A level that is still asserted when its line is unmasked therefore has to be re-announced. A one-cycle software strobe does this by forcing one message, so level-triggered behaviour can be built on top of the edge-based message scheme.

Top module: `irq_msg_agg`

## Requirements
- R1: A read at index 2 (live level) returns the raw level of all eleven inputs in bits 10:0, whatever the enable mask holds. Read data and `reg_rvalid` appear in the cycle after the read strobe.
- R2: A change of level in either direction on an implemented line (bits 0 to 8 and 10, mask 0x5FF) is recorded. Changes on bit 9 never appear in the pending or request registers and never cause a message.
- R3: The pending register (index 1) records edges on all implemented lines, enabled or not. The request register (index 3) records only edges on lines whose bit is set in the enable mask (index 0).
- R4: A read of the request register returns its bits and clears them. An edge that arrives in the same cycle as that read is kept for the next read.
- R5: A read of the pending register returns its bits and clears them, and leaves the live-level and request registers unchanged.
- R6: A message is launched in the cycle after a request bit goes from clear to set. `msg_valid` then stays high, with `msg_addr` and `msg_data` stable, until the cycle in which `msg_ack` is high.
- R7: The target register (index 4) splits at bit DATA_BITS (default 5). `msg_data` carries target bits 4:0, zero-extended. `msg_addr` carries the target with bits 4:0 forced to zero.
- R8: An edge on a line whose mask bit is clear produces no message, either at the time of the edge or when the line is later enabled.
- R9: A one-cycle `sw_fire` strobe launches exactly one message whatever the request state.
- R10: Triggers that arrive while a message is outstanding merge into exactly one follow-on message, launched right after the acknowledge.
- R11: After reset no message is outstanding and a read of the request register returns zero.
- R12: Only the implemented bits of the enable mask can be written (a read returns the written value ANDed with 0x5FF). Writes to the pending, live-level and request indices have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 11 | Interrupt lines, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index: 0 mask, 1 pending, 2 level, 3 request, 4 target |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| sw_fire | input | 1 | Forces one message |
| msg_valid | output | 1 | Message outstanding |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| msg_ack | input | 1 | Message accepted in this cycle |

## Verification
The assertions assume three things about the inputs. The interrupt lines are already synchronous to `clk`. Read and write strobes never occur in the same cycle. The read strobe and the interrupt lines are held low while reset is asserted, so the first cycle after reset compares against a known previous level. The stimulus changes every input only on the falling clock edge and keeps each access to a single-cycle strobe. It raises `msg_ack` only while `msg_valid` is high, and keeps reset long enough that no past-value check sees values from before the first edge.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    RA_ENABLE  = 3'd0,
    RA_PENDING = 3'd1,
    RA_LEVEL   = 3'd2,
    RA_REQUEST = 3'd3,
    RA_TARGET  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
  parameter int NL = 11,
  parameter logic [NL-1:0] IMPL = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] lines,
  input  logic [NL-1:0] enable,
  input  logic          clr_pend,
  input  logic          clr_req,
  output logic [NL-1:0] pend_bits,
  output logic [NL-1:0] req_bits,
  output logic          new_req
);
  logic [NL-1:0] fresh;

  for (genvar i = 0; i < NL; i++) begin : g_line
    if (IMPL[i]) begin : g_on
      logic prev_q, pend_q, req_q, chg, req_kept;
      assign chg      = lines[i] ^ prev_q;
      assign req_kept = req_q & ~clr_req;
      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
          req_q  <= 1'b0;
        end else begin
          prev_q <= lines[i];
          pend_q <= (pend_q & ~clr_pend) | chg;
          req_q  <= req_kept | (chg & enable[i]);
        end
      end
      assign pend_bits[i] = pend_q;
      assign req_bits[i]  = req_q;
      assign fresh[i]     = chg & enable[i] & ~req_kept;
    end else begin : g_off
      assign pend_bits[i] = 1'b0;
      assign req_bits[i]  = 1'b0;
      assign fresh[i]     = 1'b0;
    end
  end

  assign new_req = |fresh;
endmodule

// File: rtl/irq_msg_launcher.sv
module irq_msg_launcher #(
  parameter int W  = 32,
  parameter int DB = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         trig,
  input  logic [W-1:0] target,
  input  logic         ack,
  output logic         valid,
  output logic [W-1:0] addr,
  output logic [W-1:0] data
);
  logic busy_q, again_q, launch;

  assign launch = busy_q ? (ack && (again_q || trig)) : trig;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      again_q <= 1'b0;
      addr    <= '0;
      data    <= '0;
    end else begin
      if (!busy_q)  busy_q <= trig;
      else if (ack) busy_q <= again_q || trig;

      if (busy_q && ack)       again_q <= 1'b0;
      else if (busy_q && trig) again_q <= 1'b1;

      if (launch) begin
        addr <= {target[W-1:DB], {DB{1'b0}}};
        data <= {{(W-DB){1'b0}}, target[DB-1:0]};
      end
    end
  end

  assign valid = busy_q;
endmodule

// File: rtl/irq_msg_regs.sv
module irq_msg_regs
  import irq_msg_pkg::*;
#(
  parameter int NL = 11,
  parameter logic [NL-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [2:0]       addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [NL-1:0]    lines,
  input  logic [NL-1:0]    pend_bits,
  input  logic [NL-1:0]    req_bits,
  output logic [NL-1:0]    enable,
  output logic [REG_W-1:0] target,
  output logic             clr_pend,
  output logic             clr_req,
  output logic [REG_W-1:0] rdata,
  output logic             rvalid
);
  localparam int PADW = REG_W - NL;

  reg_sel_e         sel;
  logic [REG_W-1:0] mux;

  assign sel      = reg_sel_e'(addr);
  assign clr_pend = rd && (sel == RA_PENDING);
  assign clr_req  = rd && (sel == RA_REQUEST);

  always_comb begin
    case (sel)
      RA_ENABLE:  mux = {{PADW{1'b0}}, enable};
      RA_PENDING: mux = {{PADW{1'b0}}, pend_bits};
      RA_LEVEL:   mux = {{PADW{1'b0}}, lines};
      RA_REQUEST: mux = {{PADW{1'b0}}, req_bits};
      RA_TARGET:  mux = target;
      default:    mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      target <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= mux;
      if (wr && sel == RA_ENABLE) enable <= wdata[NL-1:0] & IMPL;
      if (wr && sel == RA_TARGET) target <= wdata;
    end
  end
endmodule

// File: rtl/irq_msg_agg.sv
module irq_msg_agg
  import irq_msg_pkg::*;
#(
  parameter int NUM_LINES = 11,
  parameter logic [NUM_LINES-1:0] IMPL_MASK = 11'h5FF,
  parameter int DATA_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [2:0]           reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 reg_rvalid,
  input  logic                 sw_fire,
  output logic                 msg_valid,
  output logic [REG_W-1:0]     msg_addr,
  output logic [REG_W-1:0]     msg_data,
  input  logic                 msg_ack
);
  logic [NUM_LINES-1:0] enable, pend_bits, req_bits;
  logic [REG_W-1:0]     target;
  logic                 clr_pend, clr_req, new_req;

  irq_msg_regs #(.NL(NUM_LINES), .IMPL(IMPL_MASK)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .lines(irq_in), .pend_bits(pend_bits),
    .req_bits(req_bits), .enable(enable), .target(target),
    .clr_pend(clr_pend), .clr_req(clr_req), .rdata(reg_rdata),
    .rvalid(reg_rvalid)
  );

  irq_edge_capture #(.NL(NUM_LINES), .IMPL(IMPL_MASK)) u_edges (
    .clk(clk), .rst(rst), .lines(irq_in), .enable(enable),
    .clr_pend(clr_pend), .clr_req(clr_req), .pend_bits(pend_bits),
    .req_bits(req_bits), .new_req(new_req)
  );

  irq_msg_launcher #(.W(REG_W), .DB(DATA_BITS)) u_launch (
    .clk(clk), .rst(rst), .trig(new_req | sw_fire), .target(target),
    .ack(msg_ack), .valid(msg_valid), .addr(msg_addr), .data(msg_data)
  );
endmodule

// File: rtl/irq_msg_agg_chk.sv
module irq_msg_agg_chk
  import irq_msg_pkg::*;
#(
  parameter int NL = 11,
  parameter int DB = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [NL-1:0]    irq_in,
  input logic             reg_rd,
  input logic [2:0]       reg_addr,
  input logic [REG_W-1:0] reg_rdata,
  input logic             reg_rvalid,
  input logic             sw_fire,
  input logic             msg_valid,
  input logic [REG_W-1:0] msg_addr,
  input logic [REG_W-1:0] msg_data,
  input logic             msg_ack,
  input logic [NL-1:0]    req_bits
);
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ack |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  a_r6_launch_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(sw_fire) || ((req_bits & ~$past(req_bits)) != '0));

  a_r1_level_view: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == RA_LEVEL |=> reg_rvalid && reg_rdata == REG_W'($past(irq_in)));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    reg_rd && reg_addr == RA_REQUEST && irq_in == $past(irq_in) && !$past(rst)
    |=> req_bits == '0);

  a_r7_split: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> msg_addr[DB-1:0] == '0 && msg_data[REG_W-1:DB] == '0);
endmodule

bind irq_msg_agg irq_msg_agg_chk #(.NL(NUM_LINES), .DB(DATA_BITS)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .sw_fire(sw_fire),
  .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
  .msg_ack(msg_ack), .req_bits(req_bits)
);

// File: tb/irq_msg_agg_bench.sv
module irq_msg_agg_bench;
  localparam logic [31:0] IMPL = 32'h5FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] irq_in = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, sw_fire = 1'b0, ack_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, msg_addr, msg_data;
  logic        reg_rvalid, msg_valid, msg_ack;

  int checks = 0, fails = 0, msg_seen = 0;

  always #2.5 clk = ~clk;
  assign msg_ack = ack_en & msg_valid;

  irq_msg_agg u_irq_msg_agg (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .sw_fire(sw_fire), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data), .msg_ack(msg_ack)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Reference model: behavioural state updated on each rising edge
  logic [31:0] m_mask, m_target, m_prev, m_pend, m_req, m_rdata, m_addr, m_data;
  logic        m_busy, m_again, m_rvalid;
  string       m_rtag;

  always @(posedge clk) begin
    logic [31:0] chg, kept, newb;
    logic        fire;
    if (rst) begin
      m_mask = 0; m_target = 0; m_prev = 0; m_pend = 0; m_req = 0;
      m_rdata = 0; m_addr = 0; m_data = 0; m_busy = 0; m_again = 0;
      m_rvalid = 0; m_rtag = "R11";
    end else begin
      if (msg_valid && msg_ack) msg_seen++;
      chg = ({21'd0, irq_in} ^ m_prev) & IMPL;
      m_rvalid = reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          3'd0: begin m_rdata = m_mask;          m_rtag = "R12"; end
          3'd1: begin m_rdata = m_pend;          m_rtag = "R5";  end
          3'd2: begin m_rdata = {21'd0, irq_in}; m_rtag = "R1";  end
          3'd3: begin m_rdata = m_req;           m_rtag = "R4";  end
          3'd4: begin m_rdata = m_target;        m_rtag = "R7";  end
          default: begin m_rdata = 0;            m_rtag = "R12"; end
        endcase
      end
      kept   = (reg_rd && reg_addr == 3'd3) ? 32'd0 : m_req;
      newb   = chg & m_mask & ~kept;
      m_req  = kept | (chg & m_mask);
      m_pend = ((reg_rd && reg_addr == 3'd1) ? 32'd0 : m_pend) | chg;
      fire   = (newb != 0) || sw_fire;
      if (!m_busy) begin
        if (fire) begin
          m_busy = 1; m_addr = m_target & ~32'h1F; m_data = m_target & 32'h1F;
        end
      end else if (msg_ack) begin
        if (m_again || fire) begin
          m_addr = m_target & ~32'h1F; m_data = m_target & 32'h1F;
        end else m_busy = 0;
        m_again = 0;
      end else if (fire) m_again = 1;
      if (reg_wr && reg_addr == 3'd0) m_mask = reg_wdata & IMPL;
      if (reg_wr && reg_addr == 3'd4) m_target = reg_wdata;
      m_prev = {21'd0, irq_in};
    end
  end

  // Every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(msg_valid == m_busy, "R6 msg_valid vs model", 32'(msg_valid), 32'(m_busy));
      if (m_busy) begin
        chk(msg_addr == m_addr, "R7 msg_addr vs model", msg_addr, m_addr);
        chk(msg_data == m_data, "R7 msg_data vs model", msg_data, m_data);
      end
      chk(reg_rvalid == m_rvalid, "R1 rvalid vs model", 32'(reg_rvalid), 32'(m_rvalid));
      if (m_rvalid) chk(reg_rdata == m_rdata, m_rtag, reg_rdata, m_rdata);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    int n0;
    tick(4);
    rst = 1'b0;
    rd(3'd3, v); chk(v == 0, "R11 request after reset", v, 0);
    chk(!msg_valid, "R11 no message after reset", 32'(msg_valid), 0);

    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk(v == 32'h5FF, "R12 mask implemented bits", v, 32'h5FF);
    wr(3'd2, 32'h7FF); wr(3'd3, 32'h7FF); rd(3'd2, v); chk(v == 0, "R12 level write ignored", v, 0);
    rd(3'd3, v); chk(v == 0, "R12 request write ignored", v, 0);
    wr(3'd4, 32'hABCD_1234);

    @(negedge clk); irq_in[3] = 1'b1;
    tick(1);
    chk(msg_valid, "R6 launch after edge", 32'(msg_valid), 1);
    chk(msg_addr == 32'hABCD_1220, "R7 address split", msg_addr, 32'hABCD_1220);
    chk(msg_data == 32'h14, "R7 data split", msg_data, 32'h14);
    tick(3); chk(msg_valid, "R6 held without ack", 32'(msg_valid), 1);
    n0 = msg_seen; ack_en = 1'b1; tick(2);
    chk(msg_seen == n0 + 1, "R6 one message accepted", msg_seen, n0 + 1);
    chk(!msg_valid, "R6 released after ack", 32'(msg_valid), 0);

    rd(3'd3, v); chk(v == 32'h8, "R4 request returns edge", v, 32'h8);
    rd(3'd3, v); chk(v == 0, "R4 request cleared", v, 0);
    rd(3'd2, v); chk(v == 32'h8, "R1 live level", v, 32'h8);
    rd(3'd1, v); chk(v == 32'h8, "R5 pending returns edge", v, 32'h8);
    rd(3'd2, v); chk(v == 32'h8, "R5 level kept after pending read", v, 32'h8);
    rd(3'd1, v); chk(v == 0, "R5 pending cleared", v, 0);

    wr(3'd0, 32'h0); n0 = msg_seen;
    @(negedge clk); irq_in[5] = 1'b1; tick(3);
    rd(3'd3, v); chk(v == 0, "R3 masked edge not requested", v, 0);
    rd(3'd1, v); chk(v == 32'h20, "R3 masked edge pending", v, 32'h20);
    wr(3'd0, 32'h20); tick(4);
    chk(msg_seen == n0, "R8 no message on unmask", msg_seen, n0);
    @(negedge clk); sw_fire = 1'b1; @(negedge clk); sw_fire = 1'b0; tick(3);
    chk(msg_seen == n0 + 1, "R9 software fire", msg_seen, n0 + 1);

    wr(3'd0, 32'h5FF); n0 = msg_seen;
    @(negedge clk); irq_in[3] = 1'b0; tick(3);
    chk(msg_seen == n0 + 1, "R2 falling edge message", msg_seen, n0 + 1);
    rd(3'd3, v); chk(v == 32'h8, "R2 falling edge request", v, 32'h8);
    n0 = msg_seen;
    @(negedge clk); irq_in[9] = 1'b1; tick(3);
    rd(3'd1, v); chk(v == 32'h8, "R2 bit 9 not pending", v, 32'h8);
    rd(3'd3, v); chk(v == 0, "R2 bit 9 not requested", v, 0);
    chk(msg_seen == n0, "R2 bit 9 no message", msg_seen, n0);
    rd(3'd2, v); chk(v == 32'h220, "R1 level ignores mask", v, 32'h220);

    ack_en = 1'b0; n0 = msg_seen;
    @(negedge clk); irq_in[0] = 1'b1; tick(2);
    @(negedge clk); sw_fire = 1'b1;
    @(negedge clk); sw_fire = 1'b0; irq_in[1] = 1'b1; tick(3);
    ack_en = 1'b1; tick(4);
    chk(msg_seen == n0 + 2, "R10 merged follow-on", msg_seen, n0 + 2);

    rd(3'd3, v); chk(v == 32'h3, "R4 request bits 0 and 1", v, 32'h3);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 3'd3; irq_in[2] = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
    chk(v == 0, "R4 read sees old value", v, 0);
    rd(3'd3, v); chk(v == 32'h4, "R4 same-cycle edge kept", v, 32'h4);

    tick(5);
    summary();
  end
endmodule